// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept. It watches the six destination-address bytes at the head of each frame, one byte per valid cycle. While the bytes arrive it also runs a byte-serial CRC over them. After the sixth byte it produces a registered accept decision, together with flags that say whether the destination was a multicast group or the broadcast address. The accept decision combines four tests: a match against a programmed station address, a broadcast test, a 64-bin multicast hash lookup, and a set of mode controls.

Software loads the station address and the two 32-bit hash words through a small write port. Mode controls are plain level inputs:

- receive-everything;
- accept every multicast;
- hash-multicast enable;
- broadcast enable.

They are sampled on the clock edge that takes the sixth byte. The decision and flags then stay constant until the next frame starts. This lets a receive-status word record the multicast flag of every accepted frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `decisionValid`, `accept`, `isMulticast` and `isBroadcast` are all 0.
- R2: The hash index is bits [31:26] of a CRC-32 over the six address bytes, taken in arrival order. The CRC uses reflected polynomial 0xEDB88320, a preset of all ones, least-significant bit first within each byte, and no final inversion. An index from 32 to 63 selects bit (index-32) of the upper hash word (`regSel`=3). An index from 0 to 31 selects that bit of the lower hash word (`regSel`=2). A multicast frame is accepted when `modeHashEn` is 1 and the selected bit is 1.
- R3: An address is a group address when bit 0 of its first byte is 1. `isMulticast` is 1 for a group address that is not all ones. A non-group address is never hashed: if it misses the station address, it is rejected even when every hash bit is set.
- R4: With `modeRecvAll`=1, every frame is accepted.
- R5: With `modeAllMulti`=1, every multicast frame is accepted, whatever the hash words hold.
- R6: With `modeHashEn`=0, the hash words have no effect on the decision.
- R7: The all-ones address raises `isBroadcast`. It is accepted when `modeBcastEn`=1 and rejected otherwise, unless `modeRecvAll`=1.
- R8: The station address is written in two parts:
  - `regSel`=0: bits [15:8] hold byte 0 and bits [7:0] hold byte 1.
  - `regSel`=1: bits [31:24] hold byte 2, on down to byte 5 in bits [7:0].

  An exact match with the station address is accepted.
- R9: `sofStrobe` together with `byteValid` marks byte 0 of a frame. `decisionValid` rises in the cycle after the sixth byte is sampled, and the decision stays unchanged until the next start of frame. That start-of-frame edge clears `decisionValid`. Bytes after the sixth, and bytes that arrive without a frame start, are ignored.
- R10: The mode inputs are sampled on the edge that takes the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Address byte present on `byteData` |
| sofStrobe | input | 1 | First byte of a new frame (qualified by `byteValid`) |
| byteData | input | 8 | Destination-address byte |
| modeRecvAll | input | 1 | Accept every frame |
| modeAllMulti | input | 1 | Accept every multicast frame |
| modeHashEn | input | 1 | Enable multicast hash filtering |
| modeBcastEn | input | 1 | Accept broadcast frames |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 station high, 1 station low, 2 hash lower word, 3 hash upper word |
| regWrData | input | 32 | Register write data |
| decisionValid | output | 1 | Decision available for the current frame |
| accept | output | 1 | Frame accepted |
| isMulticast | output | 1 | Destination is a multicast group |
| isBroadcast | output | 1 | Destination is the broadcast address |

## Verification
The assertions take two things for granted about the inputs. First, `sofStrobe` is only meaningful with `byteValid`, and it comes with byte 0. Second, the modes seen at the sixth byte are the ones that govern the frame. The bench keeps within these assumptions: it raises `sofStrobe` only with the first byte, and it holds the modes steady across a whole frame. It writes the station and hash registers only between frames, so the hash words never change while a lookup is in flight. Inside those limits, the bench draws addresses at random from four classes (station, broadcast, random group, random individual) and inserts idle gaps between bytes.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int HIST_W     = ADDR_W - BYTE_W;
  localparam int CRC_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int WORD_W     = 32;
  localparam int TABLE_W    = 2 * WORD_W;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic startFrame;
    logic takeByte;
    logic lastByte;
  } strobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = crcIn;
    for (int i = 0; i < BYTE_W; i++) begin
      c = (c >> 1) ^ ((c[0] ^ b[i]) ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/raf_ctrl.sv
module raf_ctrl
  import raf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    sofStrobe,
  output strobe_t strobes
);
  logic [CNT_W-1:0] byteCount;
  logic [CNT_W-1:0] countNext;
  logic             midFrame;

  assign midFrame  = (byteCount != '0) && (byteCount < CNT_W'(ADDR_BYTES));
  assign countNext = sofStrobe ? CNT_W'(1) : byteCount + 1'b1;

  always_comb begin
    strobes.startFrame = byteValid && sofStrobe;
    strobes.takeByte   = byteValid && (sofStrobe || midFrame);
    strobes.lastByte   = strobes.takeByte && (countNext == CNT_W'(ADDR_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
    end else if (strobes.takeByte) begin
      byteCount <= countNext;
    end
  end

  // R9: no byte is taken without a valid strobe on the input
  assert_idle_no_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> !strobes.takeByte);

  // R9: start and completion of the address never coincide
  assert_start_last_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.startFrame, strobes.lastByte}));

  // R9: once the sixth byte is taken, the next byte is taken only with a new frame start
  assert_extra_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte |=> (strobes.takeByte == strobes.startFrame));
endmodule

// File: rtl/raf_datapath.sv
module raf_datapath
  import raf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [BYTE_W-1:0]    byteData,
  input  logic                 modeRecvAll,
  input  logic                 modeAllMulti,
  input  logic                 modeHashEn,
  input  logic                 modeBcastEn,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [WORD_W-1:0]    regWrData,
  output logic                 decisionValid,
  output logic                 accept,
  output logic                 isMulticast,
  output logic                 isBroadcast
);
  logic [15:0]           stationHi;
  logic [WORD_W-1:0]     stationLo;
  logic [WORD_W-1:0]     hashLo;
  logic [WORD_W-1:0]     hashHi;
  logic [HIST_W-1:0]     addrHist;
  logic [CRC_W-1:0]      crcReg;

  logic [CRC_W-1:0]      crcBase;
  logic [CRC_W-1:0]      crcNext;
  logic [ADDR_W-1:0]     fullAddr;
  logic [TABLE_W-1:0]    hashTable;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic                  hashBit;
  logic                  groupBit;
  logic                  bcastHit;
  logic                  mcastHit;
  logic                  stationHit;
  logic                  acceptNext;

  // register port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stationHi <= '0;
      stationLo <= '0;
      hashLo    <= '0;
      hashHi    <= '0;
    end else if (regWrEn) begin
      case (regSel)
        2'd0:    stationHi <= regWrData[15:0];
        2'd1:    stationLo <= regWrData;
        2'd2:    hashLo    <= regWrData;
        default: hashHi    <= regWrData;
      endcase
    end
  end

  // byte-serial CRC and address history
  assign crcBase = strobes.startFrame ? '1 : crcReg;
  assign crcNext = crcByte(crcBase, byteData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg   <= '1;
      addrHist <= '0;
    end else if (strobes.takeByte) begin
      crcReg   <= crcNext;
      addrHist <= {addrHist[HIST_W-BYTE_W-1:0], byteData};
    end
  end

  // decision for the completed address
  assign fullAddr   = {addrHist, byteData};
  assign hashTable  = {hashHi, hashLo};
  assign hashIdx    = crcNext[CRC_W-1 -: HASH_IDX_W];
  assign hashBit    = hashTable[hashIdx];
  assign groupBit   = fullAddr[ADDR_W-BYTE_W];
  assign bcastHit   = &fullAddr;
  assign mcastHit   = groupBit && !bcastHit;
  assign stationHit = (fullAddr == {stationHi, stationLo});
  assign acceptNext = modeRecvAll
                   || (bcastHit && modeBcastEn)
                   || stationHit
                   || (mcastHit && (modeAllMulti || (modeHashEn && hashBit)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
      isMulticast   <= 1'b0;
      isBroadcast   <= 1'b0;
    end else if (strobes.lastByte) begin
      decisionValid <= 1'b1;
      accept        <= acceptNext;
      isMulticast   <= mcastHit;
      isBroadcast   <= bcastHit;
    end else if (strobes.startFrame) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
      isMulticast   <= 1'b0;
      isBroadcast   <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !strobes.startFrame |=>
      decisionValid && $stable(accept) && $stable(isMulticast) && $stable(isBroadcast));

  assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startFrame |=> !decisionValid);

  assert_recv_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte && modeRecvAll |=> accept && decisionValid);

  assert_all_multi_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decisionValid) && isMulticast && $past(modeAllMulti) |-> accept);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(isMulticast && isBroadcast));

  assert_bcast_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decisionValid) && isBroadcast && !$past(modeBcastEn) && !$past(modeRecvAll)
      && ($past(stationHi) != 16'hFFFF) |-> !accept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              sofStrobe,
  input  logic [7:0]        byteData,
  input  logic              modeRecvAll,
  input  logic              modeAllMulti,
  input  logic              modeHashEn,
  input  logic              modeBcastEn,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic              decisionValid,
  output logic              accept,
  output logic              isMulticast,
  output logic              isBroadcast
);
  strobe_t strobes;

  raf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .sofStrobe (sofStrobe),
    .strobes   (strobes)
  );

  raf_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .byteData      (byteData),
    .modeRecvAll   (modeRecvAll),
    .modeAllMulti  (modeAllMulti),
    .modeHashEn    (modeHashEn),
    .modeBcastEn   (modeBcastEn),
    .regWrEn       (regWrEn),
    .regSel        (regSel),
    .regWrData     (regWrData),
    .decisionValid (decisionValid),
    .accept        (accept),
    .isMulticast   (isMulticast),
    .isBroadcast   (isBroadcast)
  );
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        byteValid, sofStrobe;
  logic [7:0]  byteData;
  logic        modeRecvAll, modeAllMulti, modeHashEn, modeBcastEn;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic        decisionValid, accept, isMulticast, isBroadcast;

  int testsRun = 0;
  int testsFailed = 0;
  logic [47:0] station;
  logic [31:0] hLo, hHi;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofStrobe(sofStrobe),
    .byteData(byteData), .modeRecvAll(modeRecvAll), .modeAllMulti(modeAllMulti),
    .modeHashEn(modeHashEn), .modeBcastEn(modeBcastEn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .decisionValid(decisionValid),
    .accept(accept), .isMulticast(isMulticast), .isBroadcast(isBroadcast)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) c = (c >> 1) ^ ((c[0] ^ b[j]) ? 32'hEDB88320 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c = refCrc(a);
    return c[31:26];
  endfunction

  // {accept, multicast, broadcast}
  function automatic logic [2:0] refDecide(input logic [47:0] a);
    logic bc = (a == 48'hFFFF_FFFF_FFFF);
    logic mc = a[40] && !bc;
    logic [5:0] idx = refIdx(a);
    logic hb = (idx >= 6'd32) ? hHi[idx - 6'd32] : hLo[idx[4:0]];
    logic acc = modeRecvAll || (bc && modeBcastEn) || (a == station)
             || (mc && (modeAllMulti || (modeHashEn && hb)));
    return {acc, mc, bc};
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setStation(input logic [47:0] a);
    station = a;
    writeReg(2'd0, {16'h0, a[47:32]});   // R8: byte0 in [15:8]
    writeReg(2'd1, a[31:0]);             // R8: byte2 in [31:24]
  endtask

  task automatic setHash(input logic [31:0] lo, input logic [31:0] hi);
    hLo = lo; hHi = hi;
    writeReg(2'd2, lo);
    writeReg(2'd3, hi);
  endtask

  task automatic sendFrame(input logic [47:0] a, input bit gaps);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (gaps && i > 0 && ($urandom % 3 == 0)) begin
        byteValid = 1'b0; sofStrobe = 1'b0;
        repeat ($urandom % 3 + 1) @(negedge clk);
      end
      byteValid = 1'b1;
      sofStrobe = (i == 0);
      byteData  = a[47-8*i -: 8];
    end
    @(negedge clk);
    byteValid = 1'b0; sofStrobe = 1'b0;
  endtask

  task automatic checkFrame(input string req, input logic [47:0] a);
    logic [2:0] e = refDecide(a);
    check(req, {28'h0, decisionValid, accept, isMulticast, isBroadcast}, {28'h0, 1'b1, e});
  endtask

  task automatic setModes(input logic ra, input logic am, input logic he, input logic be);
    modeRecvAll = ra; modeAllMulti = am; modeHashEn = he; modeBcastEn = be;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  idx;
    void'($urandom(32'd20240611));
    rstN = 1'b0; byteValid = 1'b0; sofStrobe = 1'b0; byteData = '0;
    regWrEn = 1'b0; regSel = '0; regWrData = '0;
    setModes(0, 0, 0, 0);
    station = '0; hLo = '0; hHi = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {28'h0, decisionValid, accept, isMulticast, isBroadcast}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {28'h0, decisionValid, accept, isMulticast, isBroadcast}, 32'h0);

    setStation(48'h02_11_22_33_44_55);
    setHash(32'h0, 32'h0);

    // R8: station match
    sendFrame(48'h02_11_22_33_44_55, 0); checkFrame("R8", 48'h02_11_22_33_44_55);
    check("R8 accept", {31'h0, accept}, 32'h1);
    // R8: one byte off is rejected
    sendFrame(48'h02_11_22_33_44_54, 0); checkFrame("R8", 48'h02_11_22_33_44_54);
    check("R8 reject", {31'h0, accept}, 32'h0);

    // R7: broadcast on/off
    setModes(0, 0, 0, 1);
    sendFrame(48'hFFFF_FFFF_FFFF, 1); checkFrame("R7", 48'hFFFF_FFFF_FFFF);
    check("R7 bcast on", {30'h0, accept, isBroadcast}, 32'h3);
    setModes(0, 1, 1, 0);
    setHash(32'hFFFFFFFF, 32'hFFFFFFFF);
    sendFrame(48'hFFFF_FFFF_FFFF, 0); checkFrame("R7", 48'hFFFF_FFFF_FFFF);
    check("R7 bcast off", {30'h0, accept, isBroadcast}, 32'h1);

    // R2: single hash bit selects the frame
    a = 48'h01_00_5E_12_34_56;
    idx = refIdx(a);
    setModes(0, 0, 1, 0);
    if (idx >= 6'd32) setHash(32'h0, 32'h1 << (idx - 6'd32));
    else setHash(32'h1 << idx, 32'h0);
    sendFrame(a, 0); checkFrame("R2", a);
    check("R2 bit set", {31'h0, accept}, 32'h1);
    setHash(~hLo, ~hHi);
    sendFrame(a, 1); checkFrame("R2", a);
    check("R2 bit clear", {31'h0, accept}, 32'h0);
    // R2: second address with the other word
    a = 48'h33_33_00_00_00_FB;
    idx = refIdx(a);
    if (idx >= 6'd32) setHash(32'h0, 32'h1 << (idx - 6'd32));
    else setHash(32'h1 << idx, 32'h0);
    sendFrame(a, 0); checkFrame("R2", a);
    check("R2 other addr", {31'h0, accept}, 32'h1);

    // R6: hash disabled -> no effect
    setModes(0, 0, 0, 0);
    sendFrame(a, 0); checkFrame("R6", a);
    check("R6", {31'h0, accept}, 32'h0);

    // R3: individual address never hashed
    setHash(32'hFFFFFFFF, 32'hFFFFFFFF);
    setModes(0, 0, 1, 1);
    sendFrame(48'h00_AA_BB_CC_DD_EE, 0); checkFrame("R3", 48'h00_AA_BB_CC_DD_EE);
    check("R3", {30'h0, accept, isMulticast}, 32'h0);

    // R5: all-multicast with empty table
    setHash(32'h0, 32'h0);
    setModes(0, 1, 0, 0);
    sendFrame(48'h01_80_C2_00_00_0E, 0); checkFrame("R5", 48'h01_80_C2_00_00_0E);
    check("R5", {30'h0, accept, isMulticast}, 32'h3);

    // R4: receive-all on a stranger
    setModes(1, 0, 0, 0);
    sendFrame(48'h00_12_34_56_78_9A, 0); checkFrame("R4", 48'h00_12_34_56_78_9A);
    check("R4", {31'h0, accept}, 32'h1);

    // R9: extra bytes ignored, decision held
    setModes(0, 0, 0, 0);
    sendFrame(48'h02_11_22_33_44_55, 0);
    @(negedge clk); byteValid = 1'b1; byteData = 8'h00;
    @(negedge clk); byteData = 8'hFF;
    @(negedge clk); byteValid = 1'b0;
    checkFrame("R9 hold", 48'h02_11_22_33_44_55);
    // R9: start of frame clears the decision
    @(negedge clk); byteValid = 1'b1; sofStrobe = 1'b1; byteData = 8'hFF;
    @(negedge clk); byteValid = 1'b0; sofStrobe = 1'b0;
    check("R9 clear", {31'h0, decisionValid}, 32'h0);
    // R9: bytes without a frame start are ignored after that partial frame finishes
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); byteValid = 1'b1; byteData = 8'hFF;
    end
    @(negedge clk); byteValid = 1'b0;
    check("R9 complete", {28'h0, decisionValid, accept, isMulticast, isBroadcast}, 32'h9);

    // R10: modes change right after sixth byte does not alter decision
    setModes(0, 0, 0, 0);
    sendFrame(48'h00_12_34_56_78_9A, 0);
    modeRecvAll = 1'b1;
    @(negedge clk);
    check("R10", {31'h0, accept}, 32'h0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int cls = $urandom % 4;
      if (n % 40 == 0) setHash($urandom, $urandom);
      if (n % 70 == 0) setStation({$urandom, $urandom} & 48'hFEFF_FFFF_FFFF);
      case (cls)
        0: a = station;
        1: a = 48'hFFFF_FFFF_FFFF;
        2: a = {$urandom, $urandom} | 48'h0100_0000_0000;
        default: a = {$urandom, $urandom} & 48'hFEFF_FFFF_FFFF;
      endcase
      setModes(($urandom % 8) == 0, ($urandom % 4) == 0, $urandom % 2, $urandom % 2);
      sendFrame(a, 1);
      checkFrame("R2 R3 R4 R5 R6 R7 R8 random", a);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule